// File: doc/BRIEF.md
# Divider Configuration Loader

This block holds the three configuration fields that a clock synthesizer's divider logic consumes: a 3-bit test-select code, a 2-bit post-divider code and a 7-bit feedback-divider value. The fields can be written from two places. The first is a set of parallel pins gated by a parallel-load strobe. The second is a 12-bit serial shift register, which is filled one bit per serial-clock rising edge and committed by a serial-load strobe.

All inputs are sampled on a fast system clock. Edges of the serial clock are detected in that clock domain. The configuration latches are registers that behave like transparent windows. While the parallel strobe is low, the divider fields follow the parallel pins and the test field is held at zero. While the parallel strobe is high and the serial-load strobe is high, all three fields follow the shift register. In every other case the fields hold. The parallel path always wins over the serial path.

The most recently shifted-in bit is brought out as `serial_out`, so that a test multiplexer can observe the serial stream.

Top module: `dcfg_port`

## Requirements
- R1: A serial-clock rising edge is a system-clock edge at which `s_clock` is 1 after being 0 at the previous edge. At such an edge the 12-bit shift register takes `s_data` into bit 11 and moves every other bit one place down (bit k takes bit k+1). At all other edges the register holds.
- R2: `serial_out` equals shift register bit 11, which is the `s_data` value taken at the latest serial-clock rising edge. It is visible one system-clock edge after that rising edge.
- R3: The serial stream is sent in this order: T2, T1, T0, N1, N0, M6 down to M0. After twelve shifts, T sits in register bits 2..0, N in bits 4..3 and M in bits 11..5. The first-sent bit of each field is that field's most significant bit.
- R4: While `p_load` is 0, `m_val` and `n_code` take `par_m` and `par_n` at every edge, and `t_sel` is forced to 000.
- R5: At the edge where `p_load` is first seen as 1, the outputs hold the pin values of the previous edge. While `p_load` stays 1, later changes on `par_m` and `par_n` have no effect.
- R6: While `p_load` and `s_load` are both 1, `t_sel`, `n_code` and `m_val` take the decoded shift-register fields at every edge.
- R7: Once `s_load` is 0 and `p_load` is 1, all outputs hold. Further serial shifting does not change them.
- R8: When `p_load` is 0, it overrides `s_load`: the parallel pins are loaded even if `s_load` is 1.
- R9: A synchronous active-high `rst` clears the shift register, so `serial_out` is 0. It also sets `m_val` to all ones (127), `n_code` to 11 and `t_sel` to 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| s_clock | input | 1 | Serial shift clock, sampled on clk |
| s_data | input | 1 | Serial data bit |
| s_load | input | 1 | Serial commit strobe, transparent while high |
| p_load | input | 1 | Parallel strobe, pins transparent while low |
| par_m | input | 7 | Parallel feedback-divider value |
| par_n | input | 2 | Parallel post-divider code |
| t_sel | output | 3 | Active test-select code |
| n_code | output | 2 | Active post-divider code |
| m_val | output | 7 | Active feedback-divider value |
| serial_out | output | 1 | Most recently shifted-in serial bit |

## Verification
A wrong shift-register state appears on `serial_out` one system-clock edge after the next serial-clock rising edge. It also appears on all three fields one edge after `s_load` is raised with `p_load` high. A field-ordering error therefore shows up as a bit-reversed or misplaced value the first time a full 12-bit word is committed. A broken priority or hold path shows up in two ways: `t_sel` goes nonzero while `p_load` is low, or an output moves one edge after a pin change or a shift that should have been ignored.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;
  localparam int T_W_DEF = 3;
  localparam int N_W_DEF = 2;
  localparam int M_W_DEF = 7;

  // source selected for the configuration latches on a given edge
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_PAR  = 2'd1,
    SRC_SER  = 2'd2
  } src_e;

  // parallel strobe low wins; serial commit only while parallel strobe high
  function automatic src_e pick_src(input logic par_strobe, input logic ser_strobe);
    if (!par_strobe)     return SRC_PAR;
    else if (ser_strobe) return SRC_SER;
    else                 return SRC_HOLD;
  endfunction
endpackage

// File: rtl/dcfg_rise.sv
module dcfg_rise (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic prev_q;

  // during reset track the input so no false edge appears on release
  always_ff @(posedge clk) begin
    prev_q <= sig;
  end

  assign rise = sig & ~prev_q & ~rst;
endmodule

// File: rtl/dcfg_shifter.sv
module dcfg_shifter #(
  parameter int T_W = dcfg_pkg::T_W_DEF,
  parameter int N_W = dcfg_pkg::N_W_DEF,
  parameter int M_W = dcfg_pkg::M_W_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           din,
  output logic [T_W-1:0] fld_t,
  output logic [N_W-1:0] fld_n,
  output logic [M_W-1:0] fld_m,
  output logic           serial_out
);
  localparam int SR_W  = T_W + N_W + M_W;
  localparam int N_LSB = T_W;
  localparam int M_LSB = T_W + N_W;

  logic [SR_W-1:0] sr_q;

  // new bit enters at the top and walks toward bit 0
  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (shift_en) sr_q <= {din, sr_q[SR_W-1:1]};
  end

  // first-sent bit of each field is its MSB and lands at the field's low end
  for (genvar gi = 0; gi < T_W; gi++) begin : g_t
    assign fld_t[T_W-1-gi] = sr_q[gi];
  end
  for (genvar gi = 0; gi < N_W; gi++) begin : g_n
    assign fld_n[N_W-1-gi] = sr_q[N_LSB+gi];
  end
  for (genvar gi = 0; gi < M_W; gi++) begin : g_m
    assign fld_m[M_W-1-gi] = sr_q[M_LSB+gi];
  end

  assign serial_out = sr_q[SR_W-1];

  // R1: shift moves bits down and takes din at the top
  p_shift_r1: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (sr_q == {$past(din), $past(sr_q[SR_W-1:1])}));

  // R1: no serial edge, no change
  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/dcfg_latch.sv
module dcfg_latch #(
  parameter int T_W = dcfg_pkg::T_W_DEF,
  parameter int N_W = dcfg_pkg::N_W_DEF,
  parameter int M_W = dcfg_pkg::M_W_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           p_load,
  input  logic           s_load,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic [T_W-1:0] ser_t,
  input  logic [N_W-1:0] ser_n,
  input  logic [M_W-1:0] ser_m,
  output logic [T_W-1:0] t_q,
  output logic [N_W-1:0] n_q,
  output logic [M_W-1:0] m_q
);
  import dcfg_pkg::*;

  localparam logic [M_W-1:0] M_RST = '1;
  localparam logic [N_W-1:0] N_RST = '1;

  src_e src;

  always_comb src = pick_src(p_load, s_load);

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q <= '0;
      n_q <= N_RST;
      m_q <= M_RST;
    end else begin
      unique case (src)
        SRC_PAR: begin
          t_q <= '0;
          n_q <= par_n;
          m_q <= par_m;
        end
        SRC_SER: begin
          t_q <= ser_t;
          n_q <= ser_n;
          m_q <= ser_m;
        end
        default: begin
          t_q <= t_q;
          n_q <= n_q;
          m_q <= m_q;
        end
      endcase
    end
  end

  // R4 / R8: parallel strobe low forces test field to zero
  p_tzero_r4: assert property (@(posedge clk) disable iff (rst)
    !p_load |=> (t_q == '0));

  // R8: parallel pins win even with serial strobe high
  p_prio_r8: assert property (@(posedge clk) disable iff (rst)
    !p_load |=> (m_q == $past(par_m) && n_q == $past(par_n)));

  // R6: serial window copies the decoded shift register
  p_ser_r6: assert property (@(posedge clk) disable iff (rst)
    (p_load && s_load) |=> (t_q == $past(ser_t) && n_q == $past(ser_n) && m_q == $past(ser_m)));

  // R5 / R7: both windows closed, all fields hold
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (p_load && !s_load) |=> ($stable(t_q) && $stable(n_q) && $stable(m_q)));
endmodule

// File: rtl/dcfg_port.sv
module dcfg_port #(
  parameter int T_W = dcfg_pkg::T_W_DEF,
  parameter int N_W = dcfg_pkg::N_W_DEF,
  parameter int M_W = dcfg_pkg::M_W_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           s_clock,
  input  logic           s_data,
  input  logic           s_load,
  input  logic           p_load,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  output logic [T_W-1:0] t_sel,
  output logic [N_W-1:0] n_code,
  output logic [M_W-1:0] m_val,
  output logic           serial_out
);
  logic           sclk_rise;
  logic [T_W-1:0] ser_t;
  logic [N_W-1:0] ser_n;
  logic [M_W-1:0] ser_m;

  dcfg_rise u_rise (
    .clk  (clk),
    .rst  (rst),
    .sig  (s_clock),
    .rise (sclk_rise)
  );

  dcfg_shifter #(.T_W(T_W), .N_W(N_W), .M_W(M_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (sclk_rise),
    .din        (s_data),
    .fld_t      (ser_t),
    .fld_n      (ser_n),
    .fld_m      (ser_m),
    .serial_out (serial_out)
  );

  dcfg_latch #(.T_W(T_W), .N_W(N_W), .M_W(M_W)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .p_load (p_load),
    .s_load (s_load),
    .par_m  (par_m),
    .par_n  (par_n),
    .ser_t  (ser_t),
    .ser_n  (ser_n),
    .ser_m  (ser_m),
    .t_q    (t_sel),
    .n_q    (n_code),
    .m_q    (m_val)
  );

  // R2: serial_out reflects the bit taken at the latest serial edge
  p_sout_r2: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> (serial_out == $past(s_data)));
endmodule

// File: tb/dcfg_port_test.sv
module dcfg_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       s_clock, s_data, s_load, p_load;
  logic [6:0] par_m;
  logic [1:0] par_n;
  logic [2:0] t_sel;
  logic [1:0] n_code;
  logic [6:0] m_val;
  logic       serial_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcfg_port uut (
    .clk(clk), .rst(rst), .s_clock(s_clock), .s_data(s_data),
    .s_load(s_load), .p_load(p_load), .par_m(par_m), .par_n(par_n),
    .t_sel(t_sel), .n_code(n_code), .m_val(m_val), .serial_out(serial_out)
  );

  // {par_m[6:0], par_n[1:0], stream[11:0]}, stream[11] sent first (T2)
  localparam logic [20:0] VEC [0:3] = '{
    {7'd48,  2'b00, 12'b110_01_0101101},
    {7'd25,  2'b11, 12'b001_10_1110000},
    {7'd100, 2'b01, 12'b100_00_0000001},
    {7'd0,   2'b10, 12'b011_11_1111110}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [2:0] et, input logic [1:0] en, input logic [6:0] em);
    chk(req, {t_sel, n_code, m_val}, {et, en, em});
  endtask

  task automatic send_bit(input logic b);
    s_data  = b;
    s_clock = 1'b1;
    tick();
    s_clock = 1'b0;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; s_clock = 0; s_data = 0; s_load = 0; p_load = 1;
    par_m = 7'h55; par_n = 2'b01;
    @(negedge clk);
    tick(); tick();
    // R9: reset state
    chk_out("R9", 3'b000, 2'b11, 7'd127);
    chk("R9 serial_out", {11'd0, serial_out}, 12'd0);
    rst = 1'b0;
    tick();
    // R7: held after reset with both strobes closed
    chk_out("R7 post-reset hold", 3'b000, 2'b11, 7'd127);

    for (int v = 0; v < 4; v++) begin
      logic [6:0]  vm;
      logic [1:0]  vn;
      logic [11:0] st;
      {vm, vn, st} = VEC[v];
      // R4: parallel window open
      p_load = 1'b0; par_m = vm; par_n = vn;
      tick();
      chk_out("R4 parallel follow", 3'b000, vn, vm);
      // R5: close window, pins change afterward
      p_load = 1'b1;
      tick();
      par_m = ~vm; par_n = ~vn;
      tick();
      chk_out("R5 capture", 3'b000, vn, vm);
      // R1 / R2: shift the stream
      for (int i = 11; i >= 0; i--) begin
        send_bit(st[i]);
        chk("R2 serial_out", {11'd0, serial_out}, {11'd0, st[i]});
      end
      // R7: shifting alone does not reach outputs
      chk_out("R7 no commit", 3'b000, vn, vm);
      // R3 / R6: commit
      s_load = 1'b1;
      tick();
      chk_out("R3 R6 serial commit", st[11:9], st[8:7], st[6:0]);
      s_load = 1'b0;
      tick();
      // R7: shift junk after commit, outputs hold
      for (int i = 0; i < 5; i++) send_bit(i[0]);
      chk_out("R7 hold after fall", st[11:9], st[8:7], st[6:0]);
    end

    // R8: parallel low overrides serial strobe high
    s_load = 1'b1; p_load = 1'b0; par_m = 7'd33; par_n = 2'b10;
    tick();
    chk_out("R8 priority", 3'b000, 2'b10, 7'd33);
    tick();
    chk_out("R8 priority hold", 3'b000, 2'b10, 7'd33);
    // R6: raising parallel strobe with serial high hands over to the shift register
    // register now holds 5 junk bits over last stream: compute from known history
    p_load = 1'b1;
    tick();
    begin
      logic [11:0] sr;
      logic [11:0] st;
      st = VEC[3][11:0];
      // register bit k holds sent bit; last stream then bits 0,1,0,1,0 entered at top
      sr = 12'd0;
      for (int i = 11; i >= 0; i--) sr = {st[i], sr[11:1]};
      for (int i = 0; i < 5; i++) sr = {i[0], sr[11:1]};
      chk_out("R6 serial takeover", {sr[0], sr[1], sr[2]}, {sr[3], sr[4]},
              {sr[5], sr[6], sr[7], sr[8], sr[9], sr[10], sr[11]});
    end
    s_load = 1'b0;
    // R1: serial clock held high gives one shift only
    s_data = 1'b1; s_clock = 1'b1;
    tick(); tick(); tick();
    chk("R1 single shift", {11'd0, serial_out}, 12'd1);
    s_data = 1'b0;
    tick();
    chk("R1 no shift while high", {11'd0, serial_out}, 12'd1);
    s_clock = 1'b0;
    tick();
    // R9: reset again mid-operation
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk_out("R9 re-reset", 3'b000, 2'b11, 7'd127);
    chk("R9 re-reset serial_out", {11'd0, serial_out}, 12'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule